// File: doc/BRIEF.md
# Eight-bit ALU with Truth Register

This block is an 8-bit arithmetic and logic unit steered by a 5-bit operation code. One group of codes produces a data result: bitwise logic, shifts, rotates, increment, decrement, addition and subtraction. Another group does not produce data. These codes evaluate an unsigned comparison or a zero test, or they force a value, and they store a single truth bit in a register inside the block. That truth bit drives conditional execution. An issued operation whose conditional input is high takes effect only while the truth bit is 1.

The caller presents the two operands, the code and the conditional bit, and raises `issue_i` for one cycle. On the next clock edge the block registers the result, a write-enable that asks the caller to store the result, and a flag that marks a truth-bit update. The truth bit has two named states, `TR_FALSE` and `TR_TRUE`. Three transitions leave it: `TR_SET` moves it to `TR_TRUE`, `TR_CLEAR` moves it to `TR_FALSE`, and `TR_HOLD` keeps it where it is. Only an executed compare, zero test, set or clear takes `TR_SET` or `TR_CLEAR`. Every other cycle takes `TR_HOLD`.

Top module: `alu_tr_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `tr_o` is 0 (`TR_FALSE`), `result_o` is 0x00, and `wr_en_o` and `tr_upd_o` are 0. All outputs are registered. An operation issued before clock edge k shows its outputs after edge k.
- R2: Codes 00000, 00001, 00010 and 00011 give a AND b, a OR b, a XOR b and NOT b, with `wr_en_o`=1.
- R3: Codes 00100, 00101, 00110 and 00111 give a logical left shift of a, a logical right shift of a, a rotate right of a and a rotate left of a. Each moves by b[2:0] places, which is b modulo 8. `wr_en_o` is 1.
- R4: Codes 01000 to 01101 store the unsigned result of a>b, a>=b, a<b, a<=b, a==b and a!=b into `tr_o`, in that order. Each gives `tr_upd_o`=1, `wr_en_o`=0 and `result_o`=0x00.
- R5: Code 01110 stores (a==0) into `tr_o` and code 01111 stores (a!=0). Each gives `tr_upd_o`=1 and `wr_en_o`=0.
- R6: Code 10000 sets `tr_o` to 1 and code 10001 clears it. Each gives `tr_upd_o`=1 and `wr_en_o`=0.
- R7: Codes 10011, 10010, 10100 and 10101 give a+1, a-1, a+b and a-b, wrapping modulo 256, with `wr_en_o`=1.
- R8: The data codes of R2, R3 and R7 leave `tr_o` unchanged and give `tr_upd_o`=0.
- R9: With `cond_i`=1 and `tr_o`=0, an issued operation has no effect: `wr_en_o`=0, `tr_upd_o`=0, `result_o`=0x00, and `tr_o` is unchanged. With `cond_i`=1 and `tr_o`=1, the operation executes normally.
- R10: Codes 10110 to 11111 give `result_o`=0x00, `wr_en_o`=0 and `tr_upd_o`=0, and leave `tr_o` unchanged.
- R11: In a cycle without `issue_i`, the next outputs are `wr_en_o`=0 and `tr_upd_o`=0, and `tr_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Operation presented this cycle |
| cond_i | input | 1 | Execute only when truth bit is 1 |
| opcode_i | input | 5 | Operation code |
| opa_i | input | 8 | Operand a |
| opb_i | input | 8 | Operand b |
| result_o | output | 8 | Registered data result |
| wr_en_o | output | 1 | Result should be written back |
| tr_upd_o | output | 1 | Truth bit was updated |
| tr_o | output | 1 | Current truth bit |

## Verification
Every cycle, the assertions check that an idle, skipped or undefined operation raises neither output flag, and that the truth bit changes only on a cycle flagged as a truth update. They also check that the two flags are never raised together and that a set code executed under a true condition always leaves the truth bit at 1. The actual data values can only be shown by the bench's scenarios. These cover the wraparound of arithmetic, shift amounts above 7, unsigned ordering across 0x80, and the effect of a sequence of compares on later conditional operations.

// File: rtl/alu_tr_pkg.sv
package alu_tr_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_AND  = 5'b00000,
        OP_OR   = 5'b00001,
        OP_XOR  = 5'b00010,
        OP_NOT  = 5'b00011,
        OP_SHL  = 5'b00100,
        OP_SHR  = 5'b00101,
        OP_ROR  = 5'b00110,
        OP_ROL  = 5'b00111,
        OP_GT   = 5'b01000,
        OP_GE   = 5'b01001,
        OP_LT   = 5'b01010,
        OP_LE   = 5'b01011,
        OP_EQ   = 5'b01100,
        OP_NE   = 5'b01101,
        OP_ZR   = 5'b01110,
        OP_NZ   = 5'b01111,
        OP_TSET = 5'b10000,
        OP_TCLR = 5'b10001,
        OP_DEC  = 5'b10010,
        OP_INC  = 5'b10011,
        OP_ADD  = 5'b10100,
        OP_SUB  = 5'b10101
    } alu_op_e;

    typedef enum logic {
        TR_FALSE = 1'b0,
        TR_TRUE  = 1'b1
    } tr_state_e;

    typedef enum logic [1:0] {
        TR_HOLD,
        TR_SET,
        TR_CLEAR
    } tr_move_e;

    typedef enum logic [1:0] {
        CLS_DATA,
        CLS_TRUTH,
        CLS_NONE
    } op_class_e;

    function automatic op_class_e classify(input logic [OPW-1:0] code);
        op_class_e c;
        if (code[4] == 1'b0) begin
            c = code[3] ? CLS_TRUTH : CLS_DATA;
        end else if (code <= 5'b10001) begin
            c = CLS_TRUTH;
        end else if (code <= 5'b10101) begin
            c = CLS_DATA;
        end else begin
            c = CLS_NONE;
        end
        return c;
    endfunction

endpackage

// File: rtl/alu_bitops.sv
module alu_bitops #(
    parameter int W = 8
) (
    input  logic [2:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0]  amt;
    logic [2*W-1:0] dbl;
    logic [2*W-1:0] rr;
    logic [2*W-1:0] rl;

    assign amt = b_i[SW-1:0];
    assign dbl = {a_i, a_i};
    assign rr  = dbl >> amt;
    assign rl  = dbl << amt;

    always_comb begin
        unique case (sel_i)
            3'd0:    y_o = a_i & b_i;
            3'd1:    y_o = a_i | b_i;
            3'd2:    y_o = a_i ^ b_i;
            3'd3:    y_o = ~b_i;
            3'd4:    y_o = a_i << amt;
            3'd5:    y_o = a_i >> amt;
            3'd6:    y_o = rr[W-1:0];
            default: y_o = rl[2*W-1:W];
        endcase
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [2:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (sel_i)
            3'b010:  y_o = a_i - ONE;
            3'b011:  y_o = a_i + ONE;
            3'b100:  y_o = a_i + b_i;
            3'b101:  y_o = a_i - b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_truth.sv
module alu_truth #(
    parameter int W = 8
) (
    input  logic [4:0]   code_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output alu_tr_pkg::tr_move_e move_o
);
    import alu_tr_pkg::*;

    logic bit_v;

    always_comb begin
        unique case (code_i[2:0])
            3'd0:    bit_v = a_i >  b_i;
            3'd1:    bit_v = a_i >= b_i;
            3'd2:    bit_v = a_i <  b_i;
            3'd3:    bit_v = a_i <= b_i;
            3'd4:    bit_v = a_i == b_i;
            3'd5:    bit_v = a_i != b_i;
            3'd6:    bit_v = a_i == '0;
            default: bit_v = a_i != '0;
        endcase
    end

    always_comb begin
        if (code_i == OP_TSET) begin
            move_o = TR_SET;
        end else if (code_i == OP_TCLR) begin
            move_o = TR_CLEAR;
        end else if (code_i[4:3] == 2'b01) begin
            move_o = bit_v ? TR_SET : TR_CLEAR;
        end else begin
            move_o = TR_HOLD;
        end
    end
endmodule

// File: rtl/alu_tr_core.sv
module alu_tr_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic         cond_i,
    input  logic [4:0]   opcode_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic         tr_upd_o,
    output logic         tr_o
);
    import alu_tr_pkg::*;

    tr_state_e tr_state, tr_next;
    tr_move_e  move;
    op_class_e cls;
    logic      exec;
    logic [W-1:0] bit_y, arith_y, data_y;

    alu_bitops #(.W(W)) u_bitops (
        .sel_i (opcode_i[2:0]),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .y_o   (bit_y)
    );

    alu_arith #(.W(W)) u_arith (
        .sel_i (opcode_i[2:0]),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .y_o   (arith_y)
    );

    alu_truth #(.W(W)) u_truth (
        .code_i (opcode_i),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .move_o (move)
    );

    assign cls    = classify(opcode_i);
    assign exec   = issue_i && (!cond_i || (tr_state == TR_TRUE));
    assign data_y = opcode_i[4] ? arith_y : bit_y;

    always_comb begin
        tr_next = tr_state;
        if (exec && cls == CLS_TRUTH) begin
            unique case (move)
                TR_SET:   tr_next = TR_TRUE;
                TR_CLEAR: tr_next = TR_FALSE;
                default:  tr_next = tr_state;
            endcase
        end
    end

    // State register for the truth bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_state <= TR_FALSE;
        end else begin
            tr_state <= tr_next;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            tr_upd_o <= 1'b0;
        end else begin
            result_o <= (exec && cls == CLS_DATA) ? data_y : '0;
            wr_en_o  <= exec && (cls == CLS_DATA);
            tr_upd_o <= exec && (cls == CLS_TRUTH);
        end
    end

    assign tr_o = (tr_state == TR_TRUE);
endmodule

// File: rtl/alu_tr_checker.sv
module alu_tr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue_i,
    input logic         cond_i,
    input logic [4:0]   opcode_i,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic         tr_upd_o,
    input logic         tr_o
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R4: a truth update never also requests a write
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && tr_upd_o));

    // R8: truth bit moves only with a truth update
    p_tr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !tr_upd_o) |-> (tr_o == $past(tr_o)));

    // R11: idle cycle gives no flags
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(issue_i)) |-> (!wr_en_o && !tr_upd_o));

    // R9: skipped conditional has no effect
    p_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(issue_i && cond_i && !tr_o))
            |-> (!wr_en_o && !tr_upd_o && result_o == '0));

    // R10: undefined codes are inert
    p_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(issue_i && opcode_i > 5'b10101))
            |-> (!wr_en_o && !tr_upd_o && result_o == '0));

    // R6: executed set code leaves the truth bit high
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(issue_i && opcode_i == 5'b10000 && (!cond_i || tr_o)))
            |-> tr_o);
endmodule

bind alu_tr_core alu_tr_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .cond_i   (cond_i),
    .opcode_i (opcode_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .tr_upd_o (tr_upd_o),
    .tr_o     (tr_o)
);

// File: tb/tb_alu_tr_core.sv
module tb_alu_tr_core;

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] res;
        logic       wr;
        logic       tu;
        logic       tr;
    } vec_t;

    localparam int NV = 26;
    // Applied in order with cond=0; tr column is the truth bit after each row
    localparam vec_t VEC [NV] = '{
        '{5'b00000, 8'hCC, 8'hAA, 8'h88, 1'b1, 1'b0, 1'b0}, // R2 and
        '{5'b00001, 8'hCC, 8'hAA, 8'hEE, 1'b1, 1'b0, 1'b0}, // R2 or
        '{5'b00010, 8'hCC, 8'hAA, 8'h66, 1'b1, 1'b0, 1'b0}, // R2 xor
        '{5'b00011, 8'h12, 8'h0F, 8'hF0, 1'b1, 1'b0, 1'b0}, // R2 not b
        '{5'b00100, 8'h81, 8'h0B, 8'h08, 1'b1, 1'b0, 1'b0}, // R3 shl by 11 mod 8
        '{5'b00101, 8'h81, 8'h01, 8'h40, 1'b1, 1'b0, 1'b0}, // R3 shr
        '{5'b00110, 8'h81, 8'h09, 8'hC0, 1'b1, 1'b0, 1'b0}, // R3 ror by 9 mod 8
        '{5'b00111, 8'h81, 8'h02, 8'h06, 1'b1, 1'b0, 1'b0}, // R3 rol
        '{5'b01000, 8'h80, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b1}, // R4 gt unsigned
        '{5'b01001, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b1}, // R4 ge
        '{5'b01010, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0}, // R4 lt
        '{5'b01011, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b1}, // R4 le
        '{5'b01100, 8'h03, 8'h04, 8'h00, 1'b0, 1'b1, 1'b0}, // R4 eq
        '{5'b01101, 8'h03, 8'h04, 8'h00, 1'b0, 1'b1, 1'b1}, // R4 ne
        '{5'b01110, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1}, // R5 zero
        '{5'b01111, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0}, // R5 nonzero
        '{5'b10000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R6 set
        '{5'b10001, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0}, // R6 clear
        '{5'b10011, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0}, // R7 inc wrap
        '{5'b10010, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0}, // R7 dec wrap
        '{5'b10100, 8'hF0, 8'h20, 8'h10, 1'b1, 1'b0, 1'b0}, // R7 add wrap
        '{5'b10101, 8'h10, 8'h20, 8'hF0, 1'b1, 1'b0, 1'b0}, // R7 sub wrap
        '{5'b10000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R6 set
        '{5'b10100, 8'h01, 8'h02, 8'h03, 1'b1, 1'b0, 1'b1}, // R8 add keeps tr
        '{5'b10110, 8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 1'b1}, // R10 undefined
        '{5'b11111, 8'h05, 8'h05, 8'h00, 1'b0, 1'b0, 1'b1}  // R10 undefined
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_i = 1'b0;
    logic       cond_i = 1'b0;
    logic [4:0] opcode_i = '0;
    logic [7:0] opa_i = '0;
    logic [7:0] opb_i = '0;
    logic [7:0] result_o;
    logic       wr_en_o, tr_upd_o, tr_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    alu_tr_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue_i),
        .cond_i   (cond_i),
        .opcode_i (opcode_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .result_o (result_o),
        .wr_en_o  (wr_en_o),
        .tr_upd_o (tr_upd_o),
        .tr_o     (tr_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [7:0] res,
                           input logic wr, input logic tu, input logic tr);
        chk(req, "result", result_o, res);
        chk(req, "wr_en", {7'b0, wr_en_o}, {7'b0, wr});
        chk(req, "tr_upd", {7'b0, tr_upd_o}, {7'b0, tu});
        chk(req, "tr", {7'b0, tr_o}, {7'b0, tr});
    endtask

    // drive at negedge, outputs appear after next posedge, sample at following negedge
    task automatic run(input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c);
        @(negedge clk);
        issue_i = 1'b1; cond_i = c; opcode_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        issue_i = 1'b0; cond_i = 1'b0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 8'h00, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i].op, VEC[i].a, VEC[i].b, 1'b0);
            chk_all($sformatf("R2-table row %0d", i), VEC[i].res,
                    VEC[i].wr, VEC[i].tu, VEC[i].tr);
        end

        // R11 idle: tr currently 1
        @(negedge clk);
        chk_all("R11 idle", 8'h00, 1'b0, 1'b0, 1'b1);

        // R9 conditional executes when tr=1
        run(5'b10100, 8'h22, 8'h11, 1'b1);
        chk_all("R9 cond true add", 8'h33, 1'b1, 1'b0, 1'b1);
        run(5'b10001, 8'h00, 8'h00, 1'b1);
        chk_all("R9 cond true clear", 8'h00, 1'b0, 1'b1, 1'b0);
        // now tr=0: conditional ops skipped
        run(5'b10100, 8'h22, 8'h11, 1'b1);
        chk_all("R9 cond false add", 8'h00, 1'b0, 1'b0, 1'b0);
        run(5'b10000, 8'h00, 8'h00, 1'b1);
        chk_all("R9 cond false set", 8'h00, 1'b0, 1'b0, 1'b0);
        run(5'b01110, 8'h00, 8'h00, 1'b1);
        chk_all("R9 cond false zero test", 8'h00, 1'b0, 1'b0, 1'b0);

        // R3 rotate by zero, R5 nonzero true
        run(5'b00110, 8'hA5, 8'h08, 1'b0);
        chk_all("R3 ror by 8", 8'hA5, 1'b1, 1'b0, 1'b0);
        run(5'b01111, 8'h01, 8'h00, 1'b0);
        chk_all("R5 nonzero true", 8'h00, 1'b0, 1'b1, 1'b1);
        // R4 unsigned less-than across sign boundary
        run(5'b01010, 8'h7F, 8'h80, 1'b0);
        chk_all("R4 lt unsigned", 8'h00, 1'b0, 1'b1, 1'b1);

        // R1 reset mid-run clears truth bit
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset clears tr", 8'h00, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule